// File: doc/BRIEF.md
# Synchronous FIFO with programmable almost-flags

A single-clock buffer for 18-bit words whose depth is a power-of-two parameter (256, 512, 1024, 2048 or 4096). Words enter on a valid/ready write port and leave on a read port. The read port returns each word from an output register one cycle after the read is accepted. Five active-low status outputs report the buffer's occupancy: Empty, Full, Half-Full, Almost-Empty and Almost-Full. The Almost-Empty and Almost-Full thresholds come from two 12-bit offset registers.

The offset registers share the data path. While the active-low `load_n` pin is held low, the write port no longer fills the buffer. Each accepted write stores bits 11:0 of `wr_data` into one offset register, and the target alternates between the empty offset and the full offset, starting with the empty offset. In the same mode, each read request returns one offset register on `rd_data`, using a separate pointer that follows the same empty-then-full order. A synchronous active-low reset empties the buffer and reloads both offsets with a default that depends on depth.

Back-pressure works as follows. In normal mode, `wr_ready` is the Full flag inverted, and a word is taken only when `wr_valid` and `wr_ready` are both high. In offset mode, `wr_ready` is always high. The read side has no stall: `rd_ready` is a request, and it is honoured only when the buffer is not empty. Every request that is honoured produces exactly one cycle of `rd_valid`.

Top module: `sfifo_prog`

## Requirements
- R1: In normal mode (`load_n` high), words are returned in the order they were written, with all 18 bits intact. A read accepted at a clock edge makes `rd_valid` high and `rd_data` hold that word during the following cycle. `rd_valid` is low in every cycle that does not follow an accepted read.
- R2: In normal mode, `wr_ready` equals `full_n`, and a write is accepted only when `wr_valid` and `wr_ready` are both high. A write attempted while full is dropped, which leaves the occupancy and the stored words unchanged. In offset mode, `wr_ready` is high.
- R3: A read request while `empty_n` is low is ignored. No `rd_valid` follows it, and the occupancy does not change.
- R4: `empty_n` is low exactly when the occupancy is 0. `full_n` is low exactly when the occupancy equals DEPTH. Both flags follow the occupancy reached at the previous edge.
- R5: `half_n` is low exactly when the occupancy is greater than DEPTH/2.
- R6: `afull_n` is low exactly when the occupancy is at least DEPTH − (full offset + 1).
- R7: `aempty_n` is low exactly when the occupancy is at or below the empty offset.
- R8: While `load_n` is low, each accepted write stores `wr_data[11:0]` into an offset register and ignores bits 17:12. The first such write after reset goes to the empty offset, the next to the full offset, and then the order wraps. The buffer's contents and occupancy are untouched.
- R9: While `load_n` is low, each read request returns one offset register one cycle later, with `rd_valid` high and bits 17:12 of `rd_data` equal to zero. The order is empty offset, then full offset, then wrap, kept by a pointer separate from the load pointer. When a load and a readback of the same register happen in the same cycle, the readback returns the value from before the load.
- R10: After a synchronous reset (`rst_n` low at a clock edge), the occupancy is 0 and `rd_valid` is low. `empty_n` and `aempty_n` are low, and `full_n`, `half_n` and `afull_n` are high. Both offsets equal 31 for depth 256, 63 for depth 512, and 127 for larger depths. Both offset sequence pointers point at the empty offset.
- R11: In normal mode, a write and a read accepted at the same edge leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Low selects offset mode for both ports |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted |
| wr_data | input | 18 | Write word; bits 11:0 are the offset value in offset mode |
| rd_ready | input | 1 | Read request |
| rd_valid | output | 1 | `rd_data` holds a returned word this cycle |
| rd_data | output | 18 | Registered read word or offset value |
| empty_n | output | 1 | Low when the buffer holds no words |
| full_n | output | 1 | Low when every location holds a word |
| half_n | output | 1 | Low when more than half the locations hold words |
| aempty_n | output | 1 | Low at or below the empty offset |
| afull_n | output | 1 | Low at or above the full threshold |

## Verification
The buffer is exercised with several input patterns. A short burst of alternating and all-ones/all-zeros words checks ordering and that every bit passes through. A complete fill to the full boundary, with extra writes on top, shows that words are dropped at the full edge and that the Half-Full and almost-flag transitions fall on the exact occupancy. Simultaneous reads and writes, applied when the buffer is full, part-full and empty, tell the occupancy-holding case apart from the two edge cases where only one side is accepted. Offset traffic checks the load order, its wrap, masking of the upper bits and same-cycle load/readback. After the offsets are reprogrammed, a second fill-and-drain confirms that the flag thresholds have moved.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
  localparam int DATA_W = 18;
  localparam int OFF_W  = 12;

  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} off_sel_e;

  function automatic logic [OFF_W-1:0] default_offset(input int depth);
    if (depth <= 256)      return OFF_W'(31);
    else if (depth <= 512) return OFF_W'(63);
    else                   return OFF_W'(127);
  endfunction

  function automatic off_sel_e next_sel(input off_sel_e s);
    return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
  endfunction
endpackage

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
module sfifo_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_occupancy.sv
`timescale 1ns/1ps
module sfifo_occupancy #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] occ
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_offsets.sv
`timescale 1ns/1ps
module sfifo_offsets
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_we,
  input  logic [OFF_W-1:0] ld_data,
  input  logic             rb_re,
  output logic [OFF_W-1:0] eoff,
  output logic [OFF_W-1:0] foff,
  output logic [OFF_W-1:0] rb_data
);
  localparam logic [OFF_W-1:0] DEF_OFF = default_offset(DEPTH);

  off_sel_e         wsel_q, rsel_q;
  logic [OFF_W-1:0] off_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_off
    always_ff @(posedge clk) begin
      if (!rst_n)                                off_q[g] <= DEF_OFF;
      else if (ld_we && (wsel_q == off_sel_e'(g))) off_q[g] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel_q <= SEL_EMPTY;
      rsel_q <= SEL_EMPTY;
    end else begin
      if (ld_we) wsel_q <= next_sel(wsel_q);
      if (rb_re) rsel_q <= next_sel(rsel_q);
    end
  end

  assign eoff    = off_q[0];
  assign foff    = off_q[1];
  assign rb_data = (rsel_q == SEL_FULL) ? off_q[1] : off_q[0];
endmodule

// File: rtl/sfifo_flags.sv
`timescale 1ns/1ps
module sfifo_flags
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic [CW-1:0]    occ,
  input  logic [OFF_W-1:0] eoff,
  input  logic [OFF_W-1:0] foff,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             aempty_n,
  output logic             afull_n
);
  localparam int SW = ((CW > OFF_W) ? CW : OFF_W) + 2;

  logic [SW-1:0] occ_x, reach_x;

  assign occ_x   = SW'(occ);
  assign reach_x = occ_x + SW'(foff) + SW'(1);

  assign empty_n  = (occ != '0);
  assign full_n   = (occ != CW'(DEPTH));
  assign half_n   = !(occ > CW'(DEPTH / 2));
  assign afull_n  = !(reach_x >= SW'(DEPTH));
  assign aempty_n = !(occ_x <= SW'(eoff));
endmodule

// File: rtl/sfifo_prog.sv
`timescale 1ns/1ps
module sfifo_prog
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n,
  output logic              aempty_n,
  output logic              afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     occ_q;
  logic [DATA_W-1:0] mem_rdata;
  logic [OFF_W-1:0]  eoff, foff, rb_data;
  logic              fifo_push, fifo_pop, ld_we, rb_re;

  assign fifo_push = load_n && wr_valid && full_n;
  assign fifo_pop  = load_n && rd_ready && empty_n;
  assign ld_we     = !load_n && wr_valid;
  assign rb_re     = !load_n && rd_ready;
  assign wr_ready  = load_n ? full_n : 1'b1;

  sfifo_store #(.DEPTH(DEPTH), .DW(DATA_W)) u_store (
    .clk(clk), .we(fifo_push), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(mem_rdata)
  );

  sfifo_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
    .wptr(wptr), .rptr(rptr), .occ(occ_q)
  );

  sfifo_offsets #(.DEPTH(DEPTH)) u_offs (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_data(wr_data[OFF_W-1:0]),
    .rb_re(rb_re), .eoff(eoff), .foff(foff), .rb_data(rb_data)
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .occ(occ_q), .eoff(eoff), .foff(foff),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
    .aempty_n(aempty_n), .afull_n(afull_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= fifo_pop || rb_re;
      if (fifo_pop)   rd_data <= mem_rdata;
      else if (rb_re) rd_data <= {{(DATA_W-OFF_W){1'b0}}, rb_data};
    end
  end
endmodule

// File: rtl/sfifo_prog_chk.sv
`timescale 1ns/1ps
module sfifo_prog_chk #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic          empty_n,
  input logic          full_n,
  input logic          half_n,
  input logic          aempty_n,
  input logic          afull_n,
  input logic [CW-1:0] occ
);
  p_pop_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && rd_ready && empty_n) |=> rd_valid);

  p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && wr_valid && !full_n && !rd_ready) |=> $stable(occ));

  p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && rd_ready && !empty_n) |=> !rd_valid);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  p_flags_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  p_half_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

  p_afull_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  p_aempty_at_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  p_load_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> $stable(occ));

  p_rw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && wr_valid && wr_ready && rd_ready && empty_n) |=> $stable(occ));
endmodule

bind sfifo_prog sfifo_prog_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
  .empty_n(empty_n), .full_n(full_n), .half_n(half_n),
  .aempty_n(aempty_n), .afull_n(afull_n), .occ(occ_q)
);

// File: tb/sfifo_prog_tb_top.sv
`timescale 1ns/1ps
module sfifo_prog_tb_top;
  localparam int DEPTH = 256;
  localparam int DEF   = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_n = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [17:0] wr_data = '0;
  logic        rd_ready = 1'b0;
  logic        rd_valid;
  logic [17:0] rd_data;
  logic        empty_n, full_n, half_n, aempty_n, afull_n;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [17:0] model_q[$];
  logic [17:0] exp_q[$];
  string       tag_q[$];
  bit          pend = 1'b0;
  int          eoff_m = DEF, foff_m = DEF;
  bit          wsel_m = 1'b0, rsel_m = 1'b0;

  always #2 clk = ~clk;

  sfifo_prog #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n), .aempty_n(aempty_n), .afull_n(afull_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every returned word against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 R3", "rd_valid", 32'(rd_valid), 32'(pend));
      if (pend && rd_valid === 1'b1) begin
        if (exp_q.size() == 0) chk("R1", "scoreboard underrun", 1, 0);
        else chk(tag_q.pop_front(), "rd_data", 32'(rd_data), 32'(exp_q.pop_front()));
      end
      pend = 1'b0;
    end
  end

  task automatic check_flags();
    int n = model_q.size();
    chk("R4", "empty_n",  32'(empty_n),  32'(n != 0));
    chk("R4", "full_n",   32'(full_n),   32'(n != DEPTH));
    chk("R5", "half_n",   32'(half_n),   32'(!(n > DEPTH/2)));
    chk("R6", "afull_n",  32'(afull_n),  32'(!(n >= DEPTH - (foff_m + 1))));
    chk("R7", "aempty_n", 32'(aempty_n), 32'(!(n <= eoff_m)));
  endtask

  // driver: one clock of stimulus; updates the reference model at the edge
  task automatic cycle(input logic ld_n, input logic wv,
                       input logic [17:0] wd, input logic rr);
    int  n;
    bit  racc, wacc;
    @(negedge clk);
    check_flags();
    load_n = ld_n; wr_valid = wv; wr_data = wd; rd_ready = rr;
    n = model_q.size();
    #1;
    chk("R2", "wr_ready", 32'(wr_ready), ld_n ? 32'(n != DEPTH) : 32'd1);
    @(posedge clk);
    if (ld_n) begin
      racc = rr && (n > 0);
      wacc = wv && (n < DEPTH);
      if (racc) begin exp_q.push_back(model_q.pop_front()); tag_q.push_back("R1"); end
      if (wacc) model_q.push_back(wd);
      pend = racc;
    end else begin
      if (rr) begin
        exp_q.push_back(18'(rsel_m ? foff_m : eoff_m));
        tag_q.push_back("R9");
        rsel_m = !rsel_m;
      end
      if (wv) begin
        if (wsel_m) foff_m = int'(wd[11:0]); else eoff_m = int'(wd[11:0]);
        wsel_m = !wsel_m;
      end
      pend = rr;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; load_n = 1'b1; wr_valid = 1'b0; rd_ready = 1'b0;
    @(posedge clk); @(posedge clk);
    model_q.delete(); exp_q.delete(); tag_q.delete(); pend = 1'b0;
    eoff_m = DEF; foff_m = DEF; wsel_m = 1'b0; rsel_m = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state at the ports
    chk("R10", "empty_n",  32'(empty_n),  0);
    chk("R10", "full_n",   32'(full_n),   1);
    chk("R10", "half_n",   32'(half_n),   1);
    chk("R10", "afull_n",  32'(afull_n),  1);
    chk("R10", "aempty_n", 32'(aempty_n), 0);
    chk("R10", "rd_valid", 32'(rd_valid), 0);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R10/R9: default offsets read back in empty-then-full order
    cycle(0, 0, '0, 1);
    cycle(0, 0, '0, 1);
    cycle(1, 0, '0, 0);

    // R1: short burst, distinct bit patterns
    cycle(1, 1, 18'h3FFFF, 0);
    cycle(1, 1, 18'h00000, 0);
    cycle(1, 1, 18'h2AAAA, 0);
    cycle(1, 1, 18'h15555, 0);
    cycle(1, 1, 18'h01234, 0);
    for (int i = 0; i < 5; i++) cycle(1, 0, '0, 1);
    // R3: reads on an empty buffer
    cycle(1, 0, '0, 1);
    cycle(1, 0, '0, 1);
    cycle(1, 0, '0, 0);

    // R2 R4 R5 R6 R7: fill to full, push past it
    for (int i = 0; i < DEPTH; i++) cycle(1, 1, 18'((i * 37) ^ 18'h2C5A3), 0);
    cycle(1, 1, 18'h11111, 0);
    cycle(1, 1, 18'h22222, 0);
    // R11 edge: read and write while full, only the read is taken
    cycle(1, 1, 18'h33333, 1);
    // R11: simultaneous read and write part-full
    cycle(1, 1, 18'h04444, 1);
    cycle(1, 1, 18'h05555, 1);
    for (int i = 0; i < DEPTH; i++) cycle(1, 0, '0, 1);
    cycle(1, 0, '0, 0);
    // R11 edge: read and write while empty, only the write is taken
    cycle(1, 1, 18'h0ABCD, 1);
    cycle(1, 0, '0, 1);
    cycle(1, 0, '0, 0);

    // R8: load offsets with words resident in the buffer
    cycle(1, 1, 18'h10001, 0);
    cycle(1, 1, 18'h20002, 0);
    cycle(1, 1, 18'h30003, 0);
    cycle(0, 1, 18'h3F00A, 0);   // empty offset = 10, upper bits ignored
    cycle(0, 1, 18'h2B014, 0);   // full offset = 20
    cycle(0, 0, '0, 1);          // R9: reads 10
    cycle(0, 0, '0, 1);          // R9: reads 20
    cycle(0, 1, 18'h00005, 1);   // R8 wrap: empty offset = 5; R9 same-cycle read returns old 10
    cycle(0, 0, '0, 1);          // R9: reads 20
    cycle(0, 0, '0, 1);          // R9: reads 5
    for (int i = 0; i < 3; i++) cycle(1, 0, '0, 1);  // R8: buffer contents intact
    cycle(1, 0, '0, 0);

    // R6 R7: fill and drain against the new thresholds
    for (int i = 0; i < 240; i++) cycle(1, 1, 18'(i * 1093), 0);
    for (int i = 0; i < 240; i++) cycle(1, 0, '0, 1);
    cycle(1, 0, '0, 0);

    // R10: reset restores defaults and the sequence pointers
    cycle(1, 1, 18'h00077, 0);
    do_reset();
    cycle(0, 0, '0, 1);
    cycle(0, 0, '0, 1);
    cycle(1, 0, '0, 0);
    cycle(1, 0, '0, 0);
    chk("R1 R9", "scoreboard drained", 32'(exp_q.size()), 0);
    summary();
  end
endmodule